// File: doc/BRIEF.md
# Pseudo-Random Memory Test Pattern Generator and Checker

This block sits on both sides of a buffer memory and lets that memory be tested with a known data stream. In normal operation, burst words arriving on the input stream pass to the memory write port unchanged, one cycle later. When the test mode input is high, each accepted input word is replaced by the next word of a 16-bit pseudo-random sequence. The incoming payload is discarded, but its valid strobe still paces the output.

On the far side of the memory, the words read back arrive on an observation port. In test mode, an independent copy of the same sequence generator predicts each word. The checker compares every valid observed word with its prediction and adds one to an error counter on each mismatch. The counter saturates instead of wrapping.

The generator and the checker each advance once per valid word, so idle cycles on either side do not break alignment. Dropping the test mode input returns both generators to the seed, so the next test run starts aligned on both sides.

Top module: `mtest_pattern`

## Requirements
- R1: The sequence register is 16 bits wide. One step maps state s to {s[14:0], ~(s[15]^s[14]^s[12]^s[3])}, starting from the seed 0x0000. The all-ones state 0xFFFF is never reached, and the sequence returns to 0x0000 after exactly 65535 steps.
- R2: With test_en low, a valid input word appears on wr_data one cycle after it is accepted, unchanged.
- R3: With test_en high, the k-th accepted input word (k = 0, 1, …) since test mode was entered is output on wr_data one cycle later as the k-th sequence word (0x0000, 0x0001, 0x0003, …). in_data has no effect on the output.
- R4: wr_valid equals in_valid delayed by one cycle, in either mode.
- R5: Cycles without in_valid do not advance the write-side sequence. Cycles without rd_valid do not advance the checker sequence.
- R6: With test_en high, each valid rd_data word is compared with the checker's current sequence word. A mismatch increments err_count by one. The checker advances on every valid word, whether it matches or not.
- R7: err_count is CNT_W bits wide (default 64) and holds at its all-ones value instead of wrapping.
- R8: A cycle with test_en low returns both the generator and the checker to the seed. err_count keeps its value.
- R9: With test_en low, rd_valid and rd_data have no effect on err_count.
- R10: While rst_n is low, wr_valid, wr_data and err_count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en | input | 1 | High selects pattern injection and checking |
| in_valid | input | 1 | Input burst word valid |
| in_data | input | 16 | Input burst word |
| wr_valid | output | 1 | Memory write word valid |
| wr_data | output | 16 | Memory write word |
| rd_valid | input | 1 | Observed read-back word valid |
| rd_data | input | 16 | Observed read-back word |
| err_count | output | CNT_W | Saturating mismatch count |

## Verification
The bench runs the generator through its full period and compares every word with an arithmetic model. A wrong tap set or a plain XOR feedback would either lock up at all ones or return to the seed early.

Gaps in valid are mixed into both streams. A design that stepped every cycle, instead of once per valid word, would go out of step and report false mismatches.

A deliberate wrong word is followed by correct ones. This exposes a checker that stalls on a mismatch, because it would then count every later word as an error.

A four-bit counter is pushed past its maximum to catch wrapping. Mode toggles mid-stream show whether reseeding happens, and whether read-back words are wrongly counted outside test mode.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    localparam int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    // One step of the fixed XNOR-feedback sequence (taps 15, 14, 12, 3).
    function automatic word_t pattern_step(input word_t s);
        return {s[WORD_W-2:0], ~(s[15] ^ s[14] ^ s[12] ^ s[3])};
    endfunction

    typedef struct packed {
        logic  valid;
        word_t data;
    } beat_t;

endpackage

// File: rtl/mtp_lfsr.sv
module mtp_lfsr
    import mtp_pkg::*;
#(
    parameter word_t SEED = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  reseed,
    input  logic  advance,
    output word_t state
);

    typedef struct packed {
        word_t st;
    } lfsr_reg_t;

    lfsr_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reseed) begin
            r_d.st = SEED;
        end else if (advance) begin
            r_d.st = pattern_step(r_q.st);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

endmodule

// File: rtl/mtp_wr_path.sv
module mtp_wr_path
    import mtp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  test_en,
    input  logic  in_valid,
    input  word_t in_data,
    input  word_t pattern,
    output logic  wr_valid,
    output word_t wr_data
);

    beat_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.data = test_en ? pattern : in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wr_valid = out_q.valid;
    assign wr_data  = out_q.data;

endmodule

// File: rtl/mtp_rd_check.sv
module mtp_rd_check
    import mtp_pkg::*;
#(
    parameter word_t SEED = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  test_en,
    input  logic  rd_valid,
    input  word_t rd_data,
    output word_t expect_word,
    output logic  mismatch
);

    logic accept;

    assign accept = test_en & rd_valid;

    mtp_lfsr #(.SEED(SEED)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (~test_en),
        .advance (accept),
        .state   (expect_word)
    );

    always_comb begin
        mismatch = accept && (rd_data != expect_word);
    end

endmodule

// File: rtl/mtp_sat_counter.sv
module mtp_sat_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/mtest_pattern.sv
module mtest_pattern
    import mtp_pkg::*;
#(
    parameter int unsigned CNT_W = 64,
    parameter word_t       SEED  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic             in_valid,
    input  logic [15:0]      in_data,
    output logic             wr_valid,
    output logic [15:0]      wr_data,
    input  logic             rd_valid,
    input  logic [15:0]      rd_data,
    output logic [CNT_W-1:0] err_count
);

    word_t gen_state;
    word_t chk_state;
    logic  err_hit;

    mtp_lfsr #(.SEED(SEED)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (~test_en),
        .advance (test_en & in_valid),
        .state   (gen_state)
    );

    mtp_wr_path u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_en  (test_en),
        .in_valid (in_valid),
        .in_data  (in_data),
        .pattern  (gen_state),
        .wr_valid (wr_valid),
        .wr_data  (wr_data)
    );

    mtp_rd_check #(.SEED(SEED)) u_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_en     (test_en),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .expect_word (chk_state),
        .mismatch    (err_hit)
    );

    mtp_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_hit),
        .count (err_count)
    );

endmodule

// File: rtl/mtest_pattern_sva.sv
module mtest_pattern_sva #(
    parameter int unsigned CNT_W = 64,
    parameter logic [15:0] SEED  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_en,
    input logic             in_valid,
    input logic [15:0]      in_data,
    input logic             wr_valid,
    input logic [15:0]      wr_data,
    input logic             rd_valid,
    input logic [15:0]      rd_data,
    input logic [CNT_W-1:0] err_count,
    input logic [15:0]      gen_state,
    input logic [15:0]      chk_state
);

    localparam logic [CNT_W-1:0] C_MAX = '1;
    localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_no_lockup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_state != 16'hFFFF) && (chk_state != 16'hFFFF));

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && in_valid) |=> (wr_data == $past(in_data)));

    p_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && in_valid) |=> (wr_data == $past(gen_state)));

    p_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_valid);

    p_novalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_valid);

    p_hold_gen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !in_valid) |=> $stable(gen_state));

    p_hold_chk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !rd_valid) |=> $stable(chk_state));

    p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && rd_valid && (rd_data != chk_state) && (err_count != C_MAX))
        |=> (err_count == $past(err_count) + C_ONE));

    p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == C_MAX) |=> (err_count == C_MAX));

    p_reseed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> ((gen_state == SEED) && (chk_state == SEED)));

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (err_count == $past(err_count)));

    always @(negedge clk) begin
        if (!rst_n) begin
            a_reset_r10: assert (!wr_valid || $isunknown(wr_valid));
        end
    end

endmodule

bind mtest_pattern mtest_pattern_sva #(.CNT_W(CNT_W), .SEED(SEED)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .err_count (err_count),
    .gen_state (gen_state),
    .chk_state (chk_state)
);

// File: tb/mtest_pattern_tb.sv
`timescale 1ns/1ps
module mtest_pattern_tb;

    localparam int unsigned CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             test_en;
    logic             in_valid;
    logic [15:0]      in_data;
    logic             wr_valid;
    logic [15:0]      wr_data;
    logic             rd_valid;
    logic [15:0]      rd_data;
    logic [CNT_W-1:0] err_count;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    mtest_pattern #(.CNT_W(CNT_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .err_count (err_count)
    );

    function automatic logic [15:0] ref_next(input logic [15:0] s);
        return {s[14:0], ~(s[15] ^ s[14] ^ s[12] ^ s[3])};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; applies inputs and returns at the next falling edge.
    task automatic step(input logic iv, input logic [15:0] id,
                        input logic rv, input logic [15:0] rd);
        in_valid = iv;
        in_data  = id;
        rd_valid = rv;
        rd_data  = rd;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] g;
        logic [15:0] c;
        int          bad;
        int          early;
        rst_n = 1'b0; test_en = 1'b0;
        in_valid = 1'b0; in_data = '0; rd_valid = 1'b0; rd_data = '0;
        repeat (3) @(negedge clk);
        check(wr_valid == 1'b0, "R10 wr_valid", 64'(wr_valid), 0);
        check(wr_data == 16'h0, "R10 wr_data", 64'(wr_data), 0);
        check(err_count == '0, "R10 err_count", 64'(err_count), 0);
        rst_n = 1'b1;

        // R2 / R4: pass-through with a gap
        for (int i = 0; i < 6; i++) begin
            logic v;
            v = (i != 2);
            step(v, 16'hA5A0 + 16'(i), 1'b0, 16'h0);
            check(wr_valid == v, "R4 valid delay", 64'(wr_valid), 64'(v));
            if (v) check(wr_data == 16'hA5A0 + 16'(i), "R2 pass", 64'(wr_data), 64'(16'hA5A0 + 16'(i)));
        end

        // R3 / R5: pattern injection with gaps
        test_en = 1'b1;
        g = 16'h0000;
        for (int i = 0; i < 24; i++) begin
            logic v;
            v = ((i % 3) != 1);
            step(v, 16'hDEAD ^ 16'(i), 1'b0, 16'h0);
            check(wr_valid == v, "R4 valid in test", 64'(wr_valid), 64'(v));
            if (v) begin
                check(wr_data == g, "R3/R5 pattern word", 64'(wr_data), 64'(g));
                g = ref_next(g);
            end
        end

        // R6 / R5: checker with matching data and gaps
        c = 16'h0000;
        for (int i = 0; i < 24; i++) begin
            logic v;
            v = ((i % 4) != 0);
            step(1'b0, 16'h0, v, v ? c : 16'h1234);
            if (v) c = ref_next(c);
        end
        check(err_count == 0, "R5/R6 clean run", 64'(err_count), 0);

        // R6: mismatch counts and checker still advances
        step(1'b0, 16'h0, 1'b1, c ^ 16'h0001); c = ref_next(c);
        check(err_count == 1, "R6 first mismatch", 64'(err_count), 1);
        step(1'b0, 16'h0, 1'b1, c); c = ref_next(c);
        check(err_count == 1, "R6 advance after mismatch", 64'(err_count), 1);
        step(1'b0, 16'h0, 1'b1, ~c); c = ref_next(c);
        check(err_count == 2, "R6 second mismatch", 64'(err_count), 2);

        // R9: read-back ignored outside test mode; R2 pass-through again
        test_en = 1'b0;
        step(1'b1, 16'h4242, 1'b1, 16'hBEEF);
        check(wr_data == 16'h4242, "R2 pass after leaving", 64'(wr_data), 64'h4242);
        step(1'b0, 16'h0, 1'b1, 16'hBEEF);
        step(1'b0, 16'h0, 1'b1, 16'h1357);
        check(err_count == 2, "R9 ignored", 64'(err_count), 2);

        // R8: reseed on re-entry, count kept
        test_en = 1'b1;
        step(1'b1, 16'h7777, 1'b1, 16'h0000);
        check(wr_data == 16'h0000, "R8 generator reseeded", 64'(wr_data), 0);
        check(err_count == 2, "R8 checker reseeded", 64'(err_count), 2);
        step(1'b1, 16'h7777, 1'b1, 16'h0001);
        check(wr_data == 16'h0001, "R8 second word", 64'(wr_data), 1);
        check(err_count == 2, "R8 checker aligned", 64'(err_count), 2);

        // R7: saturation of the 4-bit counter
        c = 16'h0003;
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 16'h0, 1'b1, ~c);
            c = ref_next(c);
        end
        check(err_count == 4'hF, "R7 saturate", 64'(err_count), 64'hF);
        step(1'b0, 16'h0, 1'b1, ~c);
        check(err_count == 4'hF, "R7 hold at max", 64'(err_count), 64'hF);

        // R1: full period sweep of the write-side sequence
        test_en = 1'b0;
        step(1'b0, 16'h0, 1'b0, 16'h0);
        test_en = 1'b1;
        g = 16'h0000; bad = 0; early = 0;
        for (int i = 0; i < 65535; i++) begin
            step(1'b1, 16'(i), 1'b0, 16'h0);
            if (wr_data != g || wr_data == 16'hFFFF) begin
                bad++;
                if (bad < 4) $display("FAIL R1 word %0d actual=0x%0h expected=0x%0h", i, wr_data, g);
            end
            g = ref_next(g);
            if (g == 16'h0000 && i != 65534) early++;
        end
        check(bad == 0, "R1 full sweep words", 64'(bad), 0);
        check(early == 0, "R1 model period", 64'(early), 0);
        step(1'b1, 16'h0, 1'b0, 16'h0);
        check(wr_data == 16'h0000, "R1 period 65535", 64'(wr_data), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule